// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a burst request into the column addresses that a DRAM read or write burst visits. A request names a start column, a burst length code and a wrap order. From the next clock on, the block presents two column addresses per cycle, one for each data edge, until the burst is complete. A fixed burst of 2, 4 or 8 beats wraps inside an aligned window of that size. The block supports two wrap orders within that window: sequential and interleaved. A full-page burst walks the whole 256-column row and keeps going until the stop input ends it.

Settings that cannot be honoured are rejected. These are full page with interleaved order, full page from an odd column, and the unused length codes. In each case the block raises a one-cycle error pulse and produces no burst. Once a burst is running, a new request is not taken until the burst has ended.

Top module: `burst_col_gen`

## Requirements
- R1: Length code `bl_code` 3'b001 = 2 beats, 3'b010 = 4 beats, 3'b011 = 8 beats, 3'b111 = full page. A fixed burst of BL beats holds `valid` high for exactly BL/2 consecutive cycles.
- R2: With `interleave` = 0, beat i of a fixed burst sits at the column whose upper bits (above log2(BL)) equal those of the start column. Its low log2(BL) bits equal (start low bits + i) mod BL.
- R3: With `interleave` = 1, beat i of a fixed burst keeps the upper column bits of the start column. Its low log2(BL) bits equal the start low bits XOR i.
- R4: In burst cycle k (k = 0 first), `beat_a` carries beat 2k and `beat_b` carries beat 2k+1.
- R5: A request is sampled on the rising clock edge where `start` is high. The first pair appears in the cycle that follows, and in that cycle `beat_a` equals the requested start column.
- R6: `done` is high only in the last pair cycle of a burst. `valid` is low in the cycle after `done`.
- R7: A full-page burst presents beat i at (start + i) mod 256 and runs until `stop` is high. The pair shown in the cycle where `stop` is high is the last one, and `done` is high in that cycle. `stop` has no effect on fixed bursts.
- R8: An illegal request produces a one-cycle `err` pulse in the cycle after `start` and no `valid` cycle. The illegal requests are: full page with `interleave` = 1, full page with an odd start column, and codes 000, 100, 101 and 110.
- R9: `start` is ignored while `valid` is high, including the `done` cycle. After reset, `valid`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request |
| start_col | input | 8 | First column of the burst |
| bl_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 = interleaved wrap order, 0 = sequential |
| stop | input | 1 | Ends a full-page burst |
| valid | output | 1 | Address pair present |
| beat_a | output | 8 | Column for the first data edge of the cycle |
| beat_b | output | 8 | Column for the second data edge of the cycle |
| done | output | 1 | Last pair of the burst |
| err | output | 1 | Request rejected |

## Verification
The bench runs every start column through each fixed length in both orders. A design that carried into the upper column bits, or that confused the sequential order with the interleaved one, would show a wrong column in some pair. Full-page bursts are run across the top of the row, which catches a generator that saturates instead of wrapping or that ignores `stop`. Each illegal combination is requested and must give an `err` pulse with no `valid`. A second request is sent both mid-burst and in the `done` cycle; a design that accepted it would restart or extend the burst.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             interleave,
  input  logic             stop,
  output logic             valid,
  output logic [COL_W-1:0] beat_a,
  output logic [COL_W-1:0] beat_b,
  output logic             done,
  output logic             err
);
  localparam logic [COL_W-1:0] ALL_ONES = '1;
  localparam logic [COL_W-1:0] STEP     = COL_W'(2);

  logic             active, fp, ilv, err_q;
  logic [COL_W-1:0] base, mask, idx;

  logic             code_ok, code_fp;
  logic [COL_W-1:0] code_mask;

  always_comb begin
    code_ok   = 1'b1;
    code_fp   = 1'b0;
    code_mask = '0;
    case (bl_code)
      3'b001:  code_mask = COL_W'(1);
      3'b010:  code_mask = COL_W'(3);
      3'b011:  code_mask = COL_W'(7);
      3'b111:  begin code_fp = 1'b1; code_mask = ALL_ONES; end
      default: code_ok = 1'b0;
    endcase
  end

  wire illegal = !code_ok || (code_fp && (interleave || start_col[0]));
  wire accept  = start && !active;
  wire last    = fp ? stop : ((idx | COL_W'(1)) == mask);

  function automatic logic [COL_W-1:0] col_of(input logic [COL_W-1:0] i);
    logic [COL_W-1:0] lo;
    lo = ilv ? (base ^ i) : (base + i);
    return (base & ~mask) | (lo & mask);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      fp     <= 1'b0;
      ilv    <= 1'b0;
      err_q  <= 1'b0;
      base   <= '0;
      mask   <= '0;
      idx    <= '0;
    end else begin
      err_q <= accept && illegal;
      if (accept && !illegal) begin
        active <= 1'b1;
        base   <= start_col;
        mask   <= code_mask;
        ilv    <= interleave && !code_fp;
        fp     <= code_fp;
        idx    <= '0;
      end else if (active) begin
        if (last) active <= 1'b0;
        else      idx    <= idx + STEP;
      end
    end
  end

  assign valid  = active;
  assign done   = active && last;
  assign err    = err_q;
  assign beat_a = active ? col_of(idx) : '0;
  assign beat_b = active ? col_of(idx | COL_W'(1)) : '0;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       bl_code,
  input logic             valid,
  input logic [COL_W-1:0] beat_a,
  input logic [COL_W-1:0] beat_b,
  input logic             done,
  input logic             err
);
  logic fp_c;
  always_ff @(posedge clk) begin
    if (!rst_n)                fp_c <= 1'b0;
    else if (start && !valid)  fp_c <= (bl_code == 3'b111);
  end

  AST_ERR_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n) err |-> !valid); // R8
  AST_DONE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n) done |-> valid); // R6
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !valid); // R6
  AST_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n) $rose(valid) |-> beat_a == $past(start_col)); // R5
  AST_FP_PAIR: assert property (@(posedge clk) disable iff (!rst_n) (valid && fp_c) |-> (beat_b == beat_a + COL_W'(1))); // R7
  AST_FP_STEP: assert property (@(posedge clk) disable iff (!rst_n) (valid && $past(valid) && fp_c) |-> (beat_a == $past(beat_a) + COL_W'(2))); // R7
  AST_FP_EVEN: assert property (@(posedge clk) disable iff (!rst_n) (valid && fp_c) |-> !beat_a[0]); // R8
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col), .bl_code(bl_code),
  .valid(valid), .beat_a(beat_a), .beat_b(beat_b), .done(done), .err(err)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, interleave = 1'b0, stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] bl_code = '0;
  logic       valid, done, err;
  logic [7:0] beat_a, beat_b;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  burst_col_gen #(.COL_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col), .bl_code(bl_code),
    .interleave(interleave), .stop(stop), .valid(valid), .beat_a(beat_a), .beat_b(beat_b),
    .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int got, input int expv);
    n_chk++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, got, expv, $time);
    end
  endtask

  function automatic int exp_col(input int col, input int i, input int bl, input bit ilv);
    int lo = col % bl;
    int nl = ilv ? (lo ^ i) : ((lo + i) % bl);
    return col - lo + nl;
  endfunction

  task automatic request(input int col, input logic [2:0] code, input bit ilv);
    @(negedge clk);
    start = 1'b1; start_col = 8'(col); bl_code = code; interleave = ilv;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_fixed(input int col, input logic [2:0] code, input bit ilv,
                           input bit hold_stop, input bit poke);
    int bl = 1 << code;
    string rq = ilv ? "R3" : "R2";
    request(col, code, ilv);
    stop = hold_stop;
    for (int k = 0; k < bl/2; k++) begin
      if (poke && (k == 1 || k == bl/2 - 1)) begin
        start = 1'b1; start_col = 8'((col + 37) % 256);
      end
      #1;
      chk("R1 valid", int'(valid), 1);
      chk({rq, " R4 beat_a"}, int'(beat_a), exp_col(col, 2*k, bl, ilv));
      chk({rq, " R4 beat_b"}, int'(beat_b), exp_col(col, 2*k+1, bl, ilv));
      chk("R6 done", int'(done), (k == bl/2 - 1) ? 1 : 0);
      if (k == 0) chk("R5 first", int'(beat_a), col);
      @(negedge clk);
      start = 1'b0;
    end
    stop = 1'b0;
    #1;
    chk(poke ? "R9 ignored start" : "R1 end", int'(valid), 0);
  endtask

  task automatic run_fp(input int col, input int pairs);
    request(col, 3'b111, 1'b0);
    for (int k = 0; k < pairs; k++) begin
      stop = (k == pairs - 1);
      #1;
      chk("R7 valid", int'(valid), 1);
      chk("R7 beat_a", int'(beat_a), (col + 2*k) % 256);
      chk("R7 beat_b", int'(beat_b), (col + 2*k + 1) % 256);
      chk("R7 done", int'(done), (k == pairs - 1) ? 1 : 0);
      @(negedge clk);
    end
    stop = 1'b0;
    #1;
    chk("R7 end", int'(valid), 0);
  endtask

  task automatic run_bad(input int col, input logic [2:0] code, input bit ilv);
    request(col, code, ilv);
    #1;
    chk("R8 err", int'(err), 1);
    chk("R8 no valid", int'(valid), 0);
    @(negedge clk);
    #1;
    chk("R8 err pulse", int'(err), 0);
    chk("R8 still idle", int'(valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset valid", int'(valid), 0);
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset err", int'(err), 0);
    rst_n = 1'b1;
    for (int c = 0; c < 256; c++)
      for (int code = 1; code <= 3; code++)
        for (int o = 0; o < 2; o++)
          run_fixed(c, 3'(code), o[0], 1'b0, 1'b0);
    run_fixed(5, 3'b011, 1'b0, 1'b1, 1'b0);
    run_fixed(6, 3'b010, 1'b1, 1'b1, 1'b0);
    run_fixed(13, 3'b011, 1'b1, 1'b0, 1'b1);
    run_fixed(42, 3'b011, 1'b0, 1'b0, 1'b1);
    run_fp(250, 130);
    run_fp(0, 1);
    run_fp(100, 7);
    run_bad(4, 3'b111, 1'b1);
    run_bad(9, 3'b111, 1'b0);
    run_bad(8, 3'b000, 1'b0);
    run_bad(8, 3'b100, 1'b0);
    run_bad(8, 3'b101, 1'b1);
    run_bad(8, 3'b110, 1'b0);
    run_fixed(200, 3'b001, 1'b0, 1'b0, 1'b0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule